// File: doc/BRIEF.md
# Extended Match Timer Channel Group

This block holds a set of extra timer channels that sit beside a basic system timer. Each channel owns a 32-bit up-counter, a 32-bit compare value and a control word. The control word chooses which of several externally generated tick-enable strobes advances the counter. It also chooses whether the counter returns to zero on a compare hit and whether the channel stays armed after a hit. The tick strobes themselves are produced elsewhere.

All channels report into one shared status word, gated by a per-channel enable mask, and drive one shared interrupt line. Software clears status bits by writing ones. On the two odd channels of the upper half, a read of the counter can capture the live count of the channel just below into a read-only capture register, so two counters can be sampled as a pair. A build parameter removes the group. With the group removed, every access reports a bus error.

Top module: `xtimer_group`

## Requirements
- R1: After reset every counter, compare value, control word, the enable mask, the status word and the capture register read zero, `irq_o` is low, and no counter advances until its control word has been written.
- R2: The word address is {kind[1:0], index[2:0]}. Kind 0 is compare value, kind 1 is counter and kind 2 is control, each selecting channel index 0..7. Index i is channel i+4. Kind 3 selects index 0 = enable mask, 1 = status and 2 = capture. Control words of indices 0..3 keep only bits [7:0], and those of indices 4..7 keep bits [9:0].
- R3: Control bits [2:0] pick the rate: values 0..4 make the counter add one on each cycle where `tick_en[value]` is high, and values 5..7 stop the counter, which then holds its value.
- R4: On indices 4..7, control bit 8 set forces rate 0 whatever bits [2:0] hold.
- R5: Writing a counter loads it directly, and reading it returns the live or held count. Compare values read back as written.
- R6: A hit occurs when an armed counter advances onto its compare value. With control bit 3 set, the counter becomes zero instead of the compare value.
- R7: A counter read of index 5 or 7 whose control bit 9 is set copies the current count of index 4 or 6 into the capture register. Without bit 9 the capture register is left unchanged.
- R8: Writing a channel's compare value or counter arms it. With control bit 6 clear a channel disarms after one hit, and with bit 6 set it stays armed and hits again.
- R9: A hit on channel n (n = index+4) sets status bit n only when enable bit n is set. `irq_o` is high whenever any status bit 4..11 is set.
- R10: A status write clears the bits written as one. `irq_o` falls only after a write that clears at least one set bit and leaves bits 4..11 all zero.
- R11: Kind 3 with index 3..7 raises `bus_err` with zero read data and has no effect. With the group absent (PRESENT = 0) every access raises `bus_err`.
- R12: A write to the capture register is ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | NRATES | Rate strobes, one per selectable rate |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | log2(NCH)+2 | Word address {kind, index} |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, valid in the request cycle |
| bus_err | output | 1 | Access to an undecoded or absent register |
| irq_o | output | 1 | Shared channel interrupt |

## Verification
Read data and `bus_err` are combinational, so they are due in the same cycle as the request. A write shows up on any read issued in a later cycle. A tick strobe held for one cycle moves the counter at the next rising edge, and any status bit and `irq_o` change at that same edge. The bench therefore drives every request and strobe on the falling edge and samples one nanosecond later. It leaves one idle cycle between operations, so each read sees all earlier effects and nothing later. The expected read values are queued by the driver and compared by a monitor when the read appears on the bus.

// File: rtl/xtimer_pkg.sv
package xtimer_pkg;

    typedef enum logic [1:0] {
        K_MATCH = 2'd0,
        K_COUNT = 2'd1,
        K_CTRL  = 2'd2,
        K_MISC  = 2'd3
    } reg_kind_e;

    localparam int unsigned CTL_W      = 10;
    localparam int unsigned CB_CLR     = 3;
    localparam int unsigned CB_REARM   = 6;
    localparam int unsigned CB_FORCE0  = 8;
    localparam int unsigned CB_SNAP    = 9;
    localparam int unsigned RATE_SLOTS = 5;

    localparam logic [CTL_W-1:0] LO_MASK = 10'h0FF;
    localparam logic [CTL_W-1:0] HI_MASK = 10'h3FF;
    localparam logic [2:0]       SEL_NONE = 3'd7;

    localparam int MISC_EN   = 0;
    localparam int MISC_ST   = 1;
    localparam int MISC_SNAP = 2;

    typedef struct packed {
        logic [2:0] sel;
        logic       clr_on_hit;
        logic       rearm;
    } chan_cfg_t;

    function automatic logic [2:0] pick_sel(logic [CTL_W-1:0] c, logic upper);
        return (upper && c[CB_FORCE0]) ? 3'd0 : c[2:0];
    endfunction

endpackage

// File: rtl/xtimer_chan.sv
module xtimer_chan
    import xtimer_pkg::*;
#(
    parameter int unsigned CW     = 32,
    parameter int unsigned NRATES = 5,
    parameter bit          UPPER  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NRATES-1:0] tick_en,
    input  logic              ctl_we,
    input  logic              cnt_we,
    input  logic              mat_we,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     mat_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              hit_o
);
    localparam logic [CTL_W-1:0] MASK = UPPER ? HI_MASK : LO_MASK;

    logic [CW-1:0]    cnt_q, mat_q, cnt_nxt;
    logic [CTL_W-1:0] ctl_q, ctl_new;
    chan_cfg_t        cfg_q;
    logic             armed_q, tick;

    assign ctl_new = wdata[CTL_W-1:0] & MASK;
    assign cnt_nxt = cnt_q + 1'b1;

    always_comb begin
        tick = 1'b0;
        for (int r = 0; r < NRATES; r++) begin
            if (r < RATE_SLOTS && cfg_q.sel == 3'(r)) tick = tick_en[r];
        end
    end

    assign hit_o = tick && armed_q && !cnt_we && (cnt_nxt == mat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            mat_q   <= '0;
            ctl_q   <= '0;
            armed_q <= 1'b0;
            cfg_q   <= '{sel: SEL_NONE, clr_on_hit: 1'b0, rearm: 1'b0};
        end else begin
            if (ctl_we) begin
                ctl_q            <= ctl_new;
                cfg_q.sel        <= pick_sel(ctl_new, UPPER);
                cfg_q.clr_on_hit <= ctl_new[CB_CLR];
                cfg_q.rearm      <= ctl_new[CB_REARM];
            end
            if (mat_we) mat_q <= wdata;
            if (mat_we || cnt_we) armed_q <= 1'b1;
            else if (hit_o && !cfg_q.rearm) armed_q <= 1'b0;
            if (cnt_we) cnt_q <= wdata;
            else if (tick) cnt_q <= (hit_o && cfg_q.clr_on_hit) ? '0 : cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;
    assign mat_o = mat_q;
    assign ctl_o = ctl_q;

endmodule

// File: rtl/xtimer_status.sv
module xtimer_status #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit,
    input  logic           en_we,
    input  logic           st_we,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] st_o,
    output logic           irq_o
);
    logic [NCH-1:0] en_q, st_q, set_v, clr_v, kept;
    logic           irq_q;

    assign set_v = hit & en_q;
    assign clr_v = st_we ? (wbits & st_q) : '0;
    assign kept  = st_q & ~clr_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (en_we) en_q <= wbits;
            st_q <= kept | set_v;
            if (|set_v) irq_q <= 1'b1;
            else if ((|clr_v) && (kept == '0)) irq_q <= 1'b0;
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/xtimer_group.sv
module xtimer_group
    import xtimer_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned FIRST_CH = 4,
    parameter int unsigned CW       = 32,
    parameter int unsigned NRATES   = 5,
    parameter bit          PRESENT  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRATES-1:0]      tick_en,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [$clog2(NCH)+1:0] bus_addr,
    input  logic [CW-1:0]          bus_wdata,
    output logic [CW-1:0]          bus_rdata,
    output logic                   bus_err,
    output logic                   irq_o
);
    localparam int unsigned IW   = $clog2(NCH);
    localparam int unsigned HALF = NCH / 2;

    reg_kind_e        kind;
    logic [IW-1:0]    idx;
    logic             acc_ok, wr_ok, rd_ok;
    logic [CW-1:0]    cnt [NCH];
    logic [CW-1:0]    mat [NCH];
    logic [CTL_W-1:0] ctl [NCH];
    logic [NCH-1:0]   hit, en_q, st_q, w_mat, w_cnt, w_ctl;
    logic             w_en, w_st, snap_ld;
    logic [CW-1:0]    snap_q, snap_src;

    assign kind = reg_kind_e'(bus_addr[IW+1:IW]);
    assign idx  = bus_addr[IW-1:0];

    always_comb begin
        acc_ok = 1'b0;
        if (PRESENT) acc_ok = (kind != K_MISC) || (int'(idx) <= MISC_SNAP);
    end

    assign wr_ok   = bus_req && bus_we && acc_ok;
    assign rd_ok   = bus_req && !bus_we && acc_ok;
    assign bus_err = bus_req && !acc_ok;
    assign w_en    = wr_ok && kind == K_MISC && int'(idx) == MISC_EN;
    assign w_st    = wr_ok && kind == K_MISC && int'(idx) == MISC_ST;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign w_mat[g] = wr_ok && kind == K_MATCH && idx == IW'(g);
        assign w_cnt[g] = wr_ok && kind == K_COUNT && idx == IW'(g);
        assign w_ctl[g] = wr_ok && kind == K_CTRL  && idx == IW'(g);

        xtimer_chan #(
            .CW(CW), .NRATES(NRATES), .UPPER(g >= HALF)
        ) u_chan (
            .clk(clk), .rst(rst), .tick_en(tick_en),
            .ctl_we(w_ctl[g]), .cnt_we(w_cnt[g]), .mat_we(w_mat[g]),
            .wdata(bus_wdata),
            .cnt_o(cnt[g]), .mat_o(mat[g]), .ctl_o(ctl[g]), .hit_o(hit[g])
        );
    end

    xtimer_status #(.NCH(NCH)) u_status (
        .clk(clk), .rst(rst), .hit(hit),
        .en_we(w_en), .st_we(w_st), .wbits(bus_wdata[FIRST_CH +: NCH]),
        .en_o(en_q), .st_o(st_q), .irq_o(irq_o)
    );

    always_comb begin
        snap_ld  = 1'b0;
        snap_src = snap_q;
        for (int i = HALF; i < NCH; i++) begin
            if ((i % 2) == 1 && rd_ok && kind == K_COUNT && idx == IW'(i)
                && ctl[i][CB_SNAP]) begin
                snap_ld  = 1'b1;
                snap_src = cnt[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (snap_ld) snap_q <= snap_src;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (kind)
                K_MATCH: bus_rdata = mat[idx];
                K_COUNT: bus_rdata = cnt[idx];
                K_CTRL:  bus_rdata = CW'(ctl[idx]);
                K_MISC: begin
                    case (int'(idx))
                        MISC_EN:   bus_rdata[FIRST_CH +: NCH] = en_q;
                        MISC_ST:   bus_rdata[FIRST_CH +: NCH] = st_q;
                        MISC_SNAP: bus_rdata = snap_q;
                        default:   bus_rdata = '0;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/xtimer_group_chk.sv
module xtimer_group_chk #(
    parameter int unsigned NCH     = 8,
    parameter int unsigned CW      = 32,
    parameter bit          PRESENT = 1'b1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_req,
    input logic                   bus_we,
    input logic [$clog2(NCH)+1:0] bus_addr,
    input logic [CW-1:0]          bus_rdata,
    input logic                   bus_err,
    input logic                   irq_o,
    input logic [NCH-1:0]         stat_q,
    input logic [CW-1:0]          snap_q
);
    localparam int unsigned IW = $clog2(NCH);

    logic [1:0]    kind;
    logic [IW-1:0] idx;
    logic          st_write, cnt_read;

    assign kind     = bus_addr[IW+1:IW];
    assign idx      = bus_addr[IW-1:0];
    assign st_write = bus_req && bus_we && !bus_err && kind == 2'd3 && idx == IW'(1);
    assign cnt_read = bus_req && !bus_we && kind == 2'd1;

    p_irq_follows_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|stat_q));

    p_clear_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
        !st_write |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_lo_ctl_width_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && !bus_err && kind == 2'd2 && int'(idx) < NCH/2)
        |-> (bus_rdata[CW-1:8] == '0));

    p_capture_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        !cnt_read |=> $stable(snap_q));

    p_err_no_data_r11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rdata == '0));

    p_absent_err_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (PRESENT == 1'b0)) |-> bus_err);

endmodule

bind xtimer_group xtimer_group_chk #(
    .NCH(NCH), .CW(CW), .PRESENT(PRESENT)
) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_o(irq_o), .stat_q(st_q), .snap_q(snap_q)
);

// File: tb/tb_xtimer_group.sv
`timescale 1ns/1ps
module tb_xtimer_group;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  tick_en = '0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, off_rdata;
    logic        bus_err, irq_o, off_err, off_irq;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    xtimer_group dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_o(irq_o)
    );

    xtimer_group #(.PRESENT(1'b0)) dut_off (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(off_rdata),
        .bus_err(off_err), .irq_o(off_irq)
    );

    localparam int KM = 0, KC = 1, KT = 2;
    localparam logic [4:0] A_EN = 5'h18, A_ST = 5'h19, A_SNAP = 5'h1A;

    function automatic logic [4:0] A(int k, int i);
        return 5'(k * 8 + i);
    endfunction

    task automatic report(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, logic exp_err, string tag);
        exp_t it;
        it.data = exp; it.err = exp_err; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic tick(logic [4:0] m, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = m;
            @(negedge clk); tick_en = '0;
        end
    endtask

    task automatic chk_irq(logic exp, string tag);
        @(negedge clk); #1;
        report(irq_o === exp, tag, 32'(irq_o), 32'(exp));
    endtask

    always begin
        @(negedge clk); #1;
        if (bus_req) begin
            report(off_err === 1'b1, "R11 absent group error", 32'(off_err), 32'd1);
            if (!bus_we) begin
                if (sb.size() == 0) begin
                    report(1'b0, "scoreboard underflow", 32'd0, 32'd0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    report(bus_rdata === it.data, it.tag, bus_rdata, it.data);
                    report(bus_err === it.err, {it.tag, " err"}, 32'(bus_err), 32'(it.err));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(A(KT, 0), 0, 0, "R1 ctrl reset");
        rd(A(KC, 0), 0, 0, "R1 count reset");
        rd(A(KM, 7), 0, 0, "R1 match reset");
        rd(A_EN, 0, 0, "R1 enable reset");
        rd(A_ST, 0, 0, "R1 status reset");
        rd(A_SNAP, 0, 0, "R1 capture reset");
        chk_irq(1'b0, "R1 irq reset");
        tick(5'h1F, 2);
        rd(A(KC, 0), 0, 0, "R1 counter stopped before control write");
        // R2 control widths
        wr(A(KT, 0), 32'hFFFF_FFFF);
        rd(A(KT, 0), 32'h0FF, 0, "R2 low control width");
        wr(A(KT, 4), 32'hFFFF_FFFF);
        rd(A(KT, 4), 32'h3FF, 0, "R2 high control width");
        // R3 rate selection
        wr(A(KT, 0), 32'h1);
        tick(5'h02, 3);
        tick(5'h01, 2);
        rd(A(KC, 0), 3, 0, "R3 counts on selected rate only");
        // R5 load and R3 stopped
        wr(A(KC, 1), 32'd10);
        wr(A(KT, 1), 32'h5);
        tick(5'h1F, 2);
        rd(A(KC, 1), 10, 0, "R3 rate 5 holds value (R5 load)");
        wr(A(KM, 1), 32'h1234);
        rd(A(KM, 1), 32'h1234, 0, "R5 compare readback");
        // R4 forced rate 0
        wr(A(KT, 4), 32'h103);
        wr(A(KC, 4), 32'd0);
        tick(5'h08, 2);
        rd(A(KC, 4), 0, 0, "R4 bits 2:0 ignored");
        tick(5'h01, 2);
        rd(A(KC, 4), 2, 0, "R4 forced rate 0 counts");
        // R6/R9 hit with clear
        wr(A_EN, 32'h50);
        wr(A(KT, 2), 32'h8);
        wr(A(KM, 2), 32'd2);
        wr(A(KC, 2), 32'd0);
        tick(5'h01, 1);
        rd(A_ST, 0, 0, "R6 no hit before compare");
        tick(5'h01, 1);
        rd(A_ST, 32'h40, 0, "R9 status bit 6 on hit");
        rd(A(KC, 2), 0, 0, "R6 counter cleared on hit");
        chk_irq(1'b1, "R9 irq on status");
        // R10 clear, R8 one-shot
        wr(A_ST, 32'h40);
        chk_irq(1'b0, "R10 irq drops when clear");
        tick(5'h01, 2);
        rd(A(KC, 2), 2, 0, "R8 one-shot disarmed, no clear");
        rd(A_ST, 0, 0, "R8 one-shot no second hit");
        // R8 periodic
        wr(A(KT, 2), 32'h48);
        wr(A(KC, 2), 32'd0);
        tick(5'h01, 2);
        rd(A_ST, 32'h40, 0, "R8 periodic first hit");
        wr(A_ST, 32'h40);
        tick(5'h01, 2);
        rd(A_ST, 32'h40, 0, "R8 periodic second hit");
        wr(A_ST, 32'h40);
        wr(A(KT, 2), 32'h5);
        // R9 disabled channel
        wr(A(KT, 3), 32'h0);
        wr(A(KM, 3), 32'd1);
        wr(A(KC, 3), 32'd0);
        tick(5'h01, 1);
        rd(A(KC, 3), 1, 0, "R6 hit without clear keeps value");
        rd(A_ST, 0, 0, "R9 disabled channel sets no status");
        chk_irq(1'b0, "R9 no irq from disabled channel");
        // R10 shared interrupt
        wr(A(KM, 0), 32'd5);
        wr(A(KC, 0), 32'd4);
        wr(A(KT, 2), 32'h8);
        wr(A(KC, 2), 32'd1);
        tick(5'h03, 1);
        rd(A_ST, 32'h50, 0, "R9 two channels hit");
        wr(A_ST, 32'h10);
        rd(A_ST, 32'h40, 0, "R10 partial clear");
        chk_irq(1'b1, "R10 irq held with bit left");
        wr(A_ST, 32'h0);
        chk_irq(1'b1, "R10 zero write keeps irq");
        wr(A_ST, 32'h80);
        rd(A_ST, 32'h40, 0, "R10 clear of unset bit");
        chk_irq(1'b1, "R10 irq kept after no-op clear");
        wr(A_ST, 32'h40);
        chk_irq(1'b0, "R10 irq drops on last clear");
        wr(A(KT, 2), 32'h5);
        // R7 capture
        wr(A(KT, 4), 32'h5);
        wr(A(KC, 4), 32'h55);
        wr(A(KT, 5), 32'h205);
        rd(A(KC, 5), 0, 0, "R5 index 5 count");
        rd(A_SNAP, 32'h55, 0, "R7 capture of held neighbour");
        wr(A(KC, 6), 32'h77);
        wr(A(KT, 7), 32'h5);
        rd(A(KC, 7), 0, 0, "R5 index 7 count");
        rd(A_SNAP, 32'h55, 0, "R7 no capture without bit 9");
        wr(A(KT, 4), 32'h100);
        tick(5'h01, 1);
        rd(A(KC, 5), 0, 0, "R5 index 5 count again");
        rd(A_SNAP, 32'h56, 0, "R7 capture of live neighbour");
        // R12 read-only capture
        wr(A_SNAP, 32'hDEAD);
        rd(A_SNAP, 32'h56, 0, "R12 capture write ignored");
        // R11 bad addresses
        rd(5'h1B, 0, 1, "R11 undecoded address");
        rd(5'h1F, 0, 1, "R11 undecoded address top");
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(A_EN, 32'h50, 0, "R11 bad write has no effect");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) report(1'b0, "scoreboard leftover", 32'(sb.size()), 0);
        finish_run();
    end
endmodule